// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the two low address bits for a four-beat burst in a synchronous pipelined memory. When an address strobe is accepted, the block captures a 2-bit starting offset. After that, each clock edge with the active-low advance input held low moves the burst one beat forward. A static order-select input chooses between two beat orders. The linear order is a wrapping increment. The interleaved order is the start offset XORed with the beat number.

The block keeps two registers: the captured start offset and a 2-bit beat counter. The output offset is formed from these two registers by a combinational function chosen by the order-select input. Upper address bits, storage, chip-enable decoding and data-path control belong to neighbouring logic.

Top module: `burst_offset_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `offset_o` is 0.
- R2: On a rising edge with `load_i` high, the start register takes `start_i` and the beat count clears to 0. From the next cycle `offset_o` equals `start_i`, whatever the other inputs were.
- R3: On a rising edge with `load_i` low and `adv_n_i` low, the beat count increments modulo 4.
- R4: On a rising edge with `load_i` low and `adv_n_i` high, both the beat count and `offset_o` hold their values.
- R5: When `order_i` is 0 (linear), `offset_o` = (start + beat) mod 4. For example, start 3 gives 3, 0, 1, 2.
- R6: When `order_i` is 1 (interleaved), `offset_o` = start XOR beat. For example, start 2 gives 2, 3, 0, 1.
- R7: After four advances the sequence returns to the start offset and repeats for as long as advance stays low.
- R8: When `load_i` and advance are active in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Address strobe accepted; capture the start offset |
| start_i | input | 2 | Starting offset (low address bits) |
| adv_n_i | input | 1 | Active-low advance |
| order_i | input | 1 | Order select: 0 for linear, 1 for interleaved (static) |
| offset_o | output | 2 | Current burst offset |

## Verification
On every cycle, the in-RTL assertions check these counter rules:
- A load leaves the beat count at zero.
- An advance moves the count up by exactly one, modulo 4.
- An idle cycle keeps the count stable.
- The output always equals the order function applied to the two registers.

Only the bench's scenarios can show the end-to-end results. These are the exact beat sequences for every start value in both orders, the wrap after four beats, and that a load wins over a simultaneous advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFS_W = 2;
  typedef logic [OFS_W-1:0] ofs_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;

  function automatic ofs_t lin_ofs(ofs_t base, ofs_t beat);
    return ofs_t'(base + beat);
  endfunction

  function automatic ofs_t ilv_ofs(ofs_t base, ofs_t beat);
    return base ^ beat;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int W = OFS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] beat_o
);
  logic         step_w;
  logic [W-1:0] beat_q;

  assign step_w = adv_i && !load_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_w) beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;

  // R2 R8
  load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_q == '0));
  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (beat_q == $past(beat_q) + 1'b1));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(beat_q));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int W = OFS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] base_o
);
  logic [W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (load_i) base_q <= start_i;
  end

  assign base_o = base_q;

  // R4
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q));
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] start_i,
  input  logic       adv_n_i,
  input  logic       order_i,
  output logic [1:0] offset_o
);
  logic adv_w;
  ofs_t base_w, beat_w, ofs_w;
  order_e ord_w;

  assign adv_w = !adv_n_i;
  assign ord_w = order_e'(order_i);

  burst_base_reg #(.W(OFS_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i), .base_o(base_w)
  );

  burst_beat_ctr #(.W(OFS_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_w), .beat_o(beat_w)
  );

  always_comb begin
    case (ord_w)
      ORD_LINEAR:     ofs_w = lin_ofs(base_w, beat_w);
      ORD_INTERLEAVE: ofs_w = ilv_ofs(base_w, beat_w);
      default:        ofs_w = base_w;
    endcase
  end

  assign offset_o = ofs_w;

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (offset_o == $past(start_i)));
  // R5
  lin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_i == 1'b0) |-> (offset_o == ofs_t'(base_w + beat_w)));
  // R6
  ilv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_i == 1'b1) |-> (offset_o == (base_w ^ beat_w)));
endmodule

// File: tb/burst_offset_seq_bench.sv
module burst_offset_seq_bench;
  logic clk = 0, rst_n = 0, load_i = 0, adv_n_i = 1, order_i = 0;
  logic [1:0] start_i = 0;
  logic [1:0] offset_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_offset_seq u_burst_offset_seq (.*);

  task automatic chk(string req, logic [1:0] exp);
    total++;
    if (offset_o !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, offset_o, exp);
    end
  endtask

  // drive at negedge; values take effect at the following posedge
  task automatic cyc(bit ld, logic [1:0] st, bit adv);
    @(negedge clk);
    load_i = ld; start_i = st; adv_n_i = !adv;
    @(negedge clk);
    load_i = 0; adv_n_i = 1;
  endtask

  function automatic logic [1:0] model(bit ord, logic [1:0] s, int n);
    logic [1:0] k = n[1:0];
    if (ord) return {s[1] ^ k[1], s[0] ^ k[0]};
    return 2'((int'(s) + n) % 4);
  endfunction

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk); chk("R1 in reset", 2'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk("R1 after reset", 2'd0);
  endtask

  task automatic t_seq(bit ord);
    order_i = ord;
    for (int s = 0; s < 4; s++) begin
      cyc(1, 2'(s), 0);
      chk(ord ? "R2 R6 load" : "R2 R5 load", 2'(s));
      for (int n = 1; n < 9; n++) begin
        cyc(0, 0, 1);
        chk(n >= 4 ? "R7 wrap" : (ord ? "R6 seq" : "R5 seq"), model(ord, 2'(s), n));
      end
    end
  endtask

  task automatic t_hold();
    order_i = 0;
    cyc(1, 2'd1, 0);
    cyc(0, 0, 1);
    chk("R3 step", 2'd2);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 2'd3, 0);
      chk("R4 hold", 2'd2);
    end
  endtask

  task automatic t_prio();
    order_i = 1;
    cyc(1, 2'd2, 0);
    cyc(0, 0, 1);
    chk("R3 step ilv", 2'd3);
    cyc(1, 2'd1, 1);
    chk("R8 load wins", 2'd1);
    cyc(0, 0, 1);
    chk("R8 then advance", 2'd0);
  endtask

  initial begin
    t_reset();
    t_seq(0);
    t_seq(1);
    t_hold();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule